// File: doc/BRIEF.md
# Overlapping 1001 Serial Sequence Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge, and flags every point where the four most recent bits, from oldest to newest, read 1, 0, 0, 1. Matches may overlap. The 1 that completes one match can also be the first bit of the next match.

The design is a Moore machine with five states and a 3-bit state register. The register never loads its next state directly. The logic computes a toggle enable for each bit, and each bit flips when its enable is set, in the way a T flip-flop behaves. The detect output is decoded from the state alone. It is high for exactly the one cycle that follows the clock edge on which the final 1 was taken. A synchronous active-high reset returns the machine to idle.

Top module: `seq1001_det`

## Requirements
- R1: One rising edge after the edge that samples the final 1 of the sequence 1,0,0,1, `hit` is 1.
- R2: Overlapping matches are each reported. For the stream 1,0,0,1,0,0,1,0,0,1, `hit` is 1 after the 4th, 7th and 10th bits.
- R3: `hit` is never 1 for two cycles in a row.
- R4: Three or more zeros in a row after a 1 discard the match in progress. For 1,0,0,0,1, `hit` stays 0 after every bit.
- R5: A run of ones keeps the last one as a candidate start. For 1,1,1,0,0,1, `hit` is 1 only after the 6th bit.
- R6: While `rst` is 1 at a rising edge, the machine goes to idle and `hit` is 0 after that edge. Any partial match is lost, so 1,0,0 followed by reset and then 1 does not detect.
- R7: For long random streams, `hit` after each bit equals 1 exactly when the last four bits taken since reset are 1,0,0,1. Bits before reset count as 0.
- R8: For the stream 1,1,0,0,1,0,0,1,0, `hit` is 1 after the 5th and 8th bits only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock; all state changes on its rising edge |
| rst  | input  | 1 | Synchronous active-high reset to idle |
| din  | input  | 1 | Serial data bit, one taken per clock |
| hit  | output | 1 | High for one cycle after a 1001 match completes |

## Verification
On every cycle, the assertions check three things:
- a detect always follows a 1 taken from the seen-100 state;
- a 0 in that state sends the machine to idle;
- `hit` is never two cycles wide and is low after reset.

Only the bench scenarios can show the rest, because it depends on a history longer than one step. This covers the exact positions of the detects in the worked stream, the overlapping and ones-run cases, the loss of progress across a reset, and agreement with a four-bit shift-register model over random data.

// File: rtl/seq1001_det.sv
module seq1001_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_ONE   = 3'd1;
  localparam logic [2:0] ST_ONEZ  = 3'd2;
  localparam logic [2:0] ST_ONEZZ = 3'd3;
  localparam logic [2:0] ST_MATCH = 3'd4;

  logic [2:0] q;
  logic [2:0] nxt;
  logic [2:0] tog;

  always_comb begin
    case (q)
      ST_IDLE:  nxt = din ? ST_ONE   : ST_IDLE;
      ST_ONE:   nxt = din ? ST_ONE   : ST_ONEZ;
      ST_ONEZ:  nxt = din ? ST_ONE   : ST_ONEZZ;
      ST_ONEZZ: nxt = din ? ST_MATCH : ST_IDLE;
      ST_MATCH: nxt = din ? ST_ONE   : ST_ONEZ;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign tog = q ^ nxt;

  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= q ^ tog;
  end

  assign hit = (q == ST_MATCH);

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> !hit); // R6
  AST_HIT_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) hit |=> !hit); // R3
  AST_HIT_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst) hit |-> $past(din)); // R1
  AST_LAST_ONE_HITS: assert property (@(posedge clk) disable iff (rst)
    (q == ST_ONEZZ && din) |=> hit); // R2
  AST_THIRD_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (q == ST_ONEZZ && !din) |=> (q == ST_IDLE)); // R4

endmodule

// File: tb/tb_seq1001_det.sv
module tb_seq1001_det;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks = 0;
  int bad = 0;
  logic [3:0] hist = 4'b0;
  bit done = 1'b0;

  localparam int NVEC = 9;
  localparam logic [0:NVEC-1] VEC_BITS = 9'b110010010;
  localparam logic [0:NVEC-1] VEC_EXP  = 9'b000010010;

  seq1001_det dut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: hit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    hist = 4'b0;
  endtask

  task automatic step(input logic b, input logic exp, input string req);
    din = b;
    @(posedge clk); #2;
    hist = {hist[2:0], b};
    check(hit, exp, req);
  endtask

  task automatic step_ref(input logic b, input string req);
    step(b, ({hist[2:0], b} == 4'b1001), req);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: hit=%b expected=completion", hit);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic prev;
    @(posedge clk); #2;
    @(posedge clk); #2;
    check(hit, 1'b0, "R6 reset state");
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) step(VEC_BITS[i], VEC_EXP[i], "R8 worked stream");

    do_reset();
    step(1,0,"R2"); step(0,0,"R2"); step(0,0,"R2"); step(1,1,"R2 first");
    step(0,0,"R2"); step(0,0,"R2"); step(1,1,"R2 second");
    step(0,0,"R2"); step(0,0,"R2"); step(1,1,"R2 third");
    step(1,0,"R3 no repeat");

    do_reset();
    step(1,0,"R4"); step(0,0,"R4"); step(0,0,"R4"); step(0,0,"R4"); step(1,0,"R4 extra zero");

    do_reset();
    step(1,0,"R5"); step(1,0,"R5"); step(1,0,"R5");
    step(0,0,"R5"); step(0,0,"R5"); step(1,1,"R5 ones run");

    do_reset();
    step(1,0,"R6"); step(0,0,"R6"); step(0,0,"R6");
    din = 1'b1;
    do_reset();
    check(hit, 1'b0, "R6 reset over 1");
    step(1,0,"R6 progress lost");

    do_reset();
    step(1,0,"R1"); step(0,0,"R1"); step(0,0,"R1"); step(1,1,"R1 detect");
    din = 1'b1;
    rst = 1'b1;
    @(posedge clk); #2;
    check(hit, 1'b0, "R6 reset clears hit");
    rst = 1'b0;
    hist = 4'b0;

    prev = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      step_ref(1'($urandom_range(0, 1)), "R7 random");
      if (prev && hit) check(hit, 1'b0, "R3 two-cycle hit");
      prev = hit;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule